// File: doc/BRIEF.md
# Programmed-Command SPI Flash Shifter

This block is a single-lane SPI master for short flash commands that software assembles byte by byte. Software fills a small bank of byte registers with the opcode and any address or parameter bytes. It writes the total number of bits to shift into a count register. It then writes a trigger bit into the command register. The block drives one complete SPI mode 0 frame. It sends the program bytes starting from the highest-indexed register and moving downward. While it sends, it captures every MISO bit into a long receive shift register.

The trigger bit stays set for the whole frame and drops on its own when the frame ends, so software only has to poll the command register. After the frame, software reads the captured reply through a byte-wide window onto the receive shift register. The most recently received byte sits at index 0. A count that is zero or too large, and any trigger other than the programmed-command bit, completes at once with no bus activity. The SCK half period, in system clock cycles, is a parameter.

Top module: `spi_prg_shifter`

## Requirements
- R1: After a synchronous reset every register reads 0x00, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0.
- R2: The register map is as follows. The command register is at 0x00 and the bit count at 0x01. Program byte i (i = 0..5) is at 0x08+i and shift byte i (i = 0..7) is at 0x10+i. Any other address reads 0x00. Command bits 3 and 6 are not stored and read 0. The count and program registers read back what was written.
- R3: Writing command bit 2 (programmed command) with a count N in 1..64 sends exactly N bits, MSB first. The bytes go out in this order: program 5, program 4, down to program 0, then zero bytes.
- R4: The bus uses SPI mode 0. SCK is low whenever CS_n is high. MOSI never changes on a rising SCK edge. Each frame has exactly N rising SCK edges.
- R5: CS_n goes low on the clock edge that accepts the command write. It stays low for exactly 2·HALF_DIV·(N+1) clock cycles, which is one SCK period after the last falling SCK edge.
- R6: MISO is sampled on each rising SCK edge into a receive register that is cleared when the frame starts. The last bit lands in bit 0 of shift byte 0. In a frame of k whole bytes, frame byte j is found at shift index k−1−j, and unused upper bytes read 0.
- R7: Command bit 2 reads 1 while CS_n is low. It clears on the same clock edge on which CS_n rises.
- R8: With bit 2 set and a count of 0 or above 64, CS_n never goes low. The trigger reads set in the cycle after the write and clear in the cycle after that. The shift bank keeps its previous contents.
- R9: Trigger bits 0, 1, 4 and 5 written without bit 2 cause no bus activity and clear one cycle after they are seen set.
- R10: Command bit 7 (auto-increment) keeps its written value through frame completion. Only a later command write changes it.
- R11: A command write made while a frame or a completion is in progress is ignored. The command readback does not change and no further frame follows.
- R12: Writes to the count or program registers during a frame update those registers but do not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The case hardest to reach from the ports is a register write that arrives while a frame is already running. This covers both a second command write and an update to the count or program bytes. Either one must leave the frame on the wire untouched. The bench starts a frame and, within a few cycles, issues these writes. It then compares the bits a serial slave model captured against the values that were in the registers when the frame started. It also confirms that exactly one CS_n window of the expected length occurred. Zero, oversize and non-programmed triggers are driven right after a frame with a known reply, so that an unwanted change to the shift bank shows up.

// File: rtl/spi_prg_pkg.sv
package spi_prg_pkg;

    localparam int ADDR_W        = 5;
    localparam int DATA_W        = 8;
    localparam int PRG_BYTES_DEF = 6;
    localparam int SHB_BYTES_DEF = 8;

    localparam logic [ADDR_W-1:0] A_CMD   = 5'h00;
    localparam logic [ADDR_W-1:0] A_CNT   = 5'h01;
    localparam logic [1:0]        WIN_PRG = 2'b01;
    localparam logic [1:0]        WIN_SHB = 2'b10;

    localparam int TRG_RD   = 0;
    localparam int TRG_RDSR = 1;
    localparam int TRG_PRG  = 2;
    localparam int TRG_WR   = 4;
    localparam int TRG_WRSR = 5;
    localparam int FLG_AINC = 7;

    localparam logic [DATA_W-1:0] CMD_WR_MASK   = 8'hB7;
    localparam logic [DATA_W-1:0] CMD_KEEP_MASK = 8'h80;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CMD,
        RK_CNT,
        RK_PRG,
        RK_SHB
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] idx;
    } reg_sel_t;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_LOW,
        EN_HIGH,
        EN_TAIL,
        EN_SKIP
    } eng_state_e;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.idx = a[2:0];
        if (a == A_CMD)
            s.kind = RK_CMD;
        else if (a == A_CNT)
            s.kind = RK_CNT;
        else if (a[4:3] == WIN_PRG)
            s.kind = RK_PRG;
        else if (a[4:3] == WIN_SHB)
            s.kind = RK_SHB;
        else
            s.kind = RK_NONE;
        return s;
    endfunction

    function automatic logic count_ok(input logic [DATA_W-1:0] c, input int max_bits);
        return (c != '0) && (int'(c) <= max_bits);
    endfunction

endpackage

// File: rtl/prg_tick.sv
module prg_tick #(
    parameter  int HALF_DIV = 2,
    localparam int CW       = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/prg_regfile.sv
module prg_regfile import spi_prg_pkg::*; #(
    parameter  int PRG_BYTES = PRG_BYTES_DEF,
    parameter  int SHB_BYTES = SHB_BYTES_DEF,
    localparam int MAX_BITS  = 8 * SHB_BYTES,
    localparam int PAD_BITS  = MAX_BITS - 8 * PRG_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic [MAX_BITS-1:0] rx_vec_i,
    output logic                go_o,
    output logic                frame_o,
    output logic [DATA_W-1:0]   count_o,
    output logic [MAX_BITS-1:0] out_vec_o,
    output logic [DATA_W-1:0]   cmd_o
);
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] prg_q [PRG_BYTES];
    reg_sel_t          sel;

    assign sel     = decode_addr(reg_addr);
    assign go_o    = reg_we && (sel.kind == RK_CMD) && !busy_i;
    assign frame_o = reg_wdata[TRG_PRG];
    assign count_o = cnt_q;
    assign cmd_o   = cmd_q;

    // Highest program index forms the first byte on the wire.
    for (genvar g = 0; g < PRG_BYTES; g++) begin : g_pack
        assign out_vec_o[MAX_BITS - 8*(PRG_BYTES - g) +: 8] = prg_q[g];
    end
    if (PAD_BITS > 0) begin : g_pad
        assign out_vec_o[PAD_BITS-1:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cnt_q <= '0;
            for (int i = 0; i < PRG_BYTES; i++)
                prg_q[i] <= '0;
        end else begin
            if (go_o)
                cmd_q <= reg_wdata & CMD_WR_MASK;
            else if (done_i)
                cmd_q <= cmd_q & CMD_KEEP_MASK;
            if (reg_we && sel.kind == RK_CNT)
                cnt_q <= reg_wdata;
            for (int i = 0; i < PRG_BYTES; i++)
                if (reg_we && sel.kind == RK_PRG && sel.idx == i[2:0])
                    prg_q[i] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel.kind)
            RK_CMD: reg_rdata = cmd_q;
            RK_CNT: reg_rdata = cnt_q;
            RK_PRG: begin
                for (int i = 0; i < PRG_BYTES; i++)
                    if (sel.idx == i[2:0])
                        reg_rdata = prg_q[i];
            end
            RK_SHB: begin
                for (int i = 0; i < SHB_BYTES; i++)
                    if (sel.idx == i[2:0])
                        reg_rdata = rx_vec_i[8*i +: 8];
            end
            default: reg_rdata = '0;
        endcase
    end

    // R11: nothing but an accepted write or a completion moves the command register
    a_r11_cmd_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !done_i) |=> $stable(cmd_q));

    // R10: completion leaves the auto-increment flag as it was
    a_r10_ainc_kept: assert property (@(posedge clk) disable iff (rst)
        done_i |=> $stable(cmd_q[FLG_AINC]));

endmodule

// File: rtl/prg_engine.sv
module prg_engine import spi_prg_pkg::*; #(
    parameter  int MAX_BITS = 64,
    parameter  int HALF_DIV = 2,
    localparam int BW       = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go_i,
    input  logic                frame_i,
    input  logic [DATA_W-1:0]   count_i,
    input  logic [MAX_BITS-1:0] tx_vec_i,
    input  logic                miso_i,
    output logic                sck_o,
    output logic                cs_n_o,
    output logic                mosi_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] rx_vec_o
);
    eng_state_e        st_q;
    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_q;
    logic [BW-1:0]     nbits_q;
    logic [BW-1:0]     idx_q;
    logic              sck_q;
    logic              cs_n_q;
    logic              tail_q;
    logic              tick;
    logic              accept;
    logic              start_ok;
    logic              shifting;

    assign accept   = go_i && (st_q == EN_IDLE);
    assign start_ok = frame_i && count_ok(count_i, MAX_BITS);
    assign shifting = (st_q == EN_LOW) || (st_q == EN_HIGH);

    prg_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept),
        .tick_o (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= EN_IDLE;
            tx_q    <= '0;
            rx_q    <= '0;
            nbits_q <= '0;
            idx_q   <= '0;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            tail_q  <= 1'b0;
        end else begin
            case (st_q)
                EN_IDLE: begin
                    if (accept) begin
                        if (start_ok) begin
                            tx_q    <= tx_vec_i;
                            rx_q    <= '0;
                            nbits_q <= BW'(count_i);
                            idx_q   <= '0;
                            cs_n_q  <= 1'b0;
                            st_q    <= EN_LOW;
                        end else begin
                            st_q <= EN_SKIP;
                        end
                    end
                end
                EN_LOW: begin
                    if (tick) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[MAX_BITS-2:0], miso_i};
                        st_q  <= EN_HIGH;
                    end
                end
                EN_HIGH: begin
                    if (tick) begin
                        sck_q <= 1'b0;
                        if (idx_q == nbits_q - 1'b1) begin
                            tail_q <= 1'b0;
                            st_q   <= EN_TAIL;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            tx_q  <= {tx_q[MAX_BITS-2:0], 1'b0};
                            st_q  <= EN_LOW;
                        end
                    end
                end
                EN_TAIL: begin
                    if (tick) begin
                        if (tail_q) begin
                            cs_n_q <= 1'b1;
                            st_q   <= EN_IDLE;
                        end else begin
                            tail_q <= 1'b1;
                        end
                    end
                end
                EN_SKIP: st_q <= EN_IDLE;
                default: st_q <= EN_IDLE;
            endcase
        end
    end

    assign sck_o    = sck_q;
    assign cs_n_o   = cs_n_q;
    assign mosi_o   = shifting ? tx_q[MAX_BITS-1] : 1'b0;
    assign busy_o   = (st_q != EN_IDLE);
    assign done_o   = (st_q == EN_SKIP) || ((st_q == EN_TAIL) && tick && tail_q);
    assign rx_vec_o = rx_q;

    // R4: clock parked low outside a selected frame
    a_r4_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> !sck_q);

    // R4: data line does not move on a rising clock edge
    a_r4_mosi_hold_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_q) |-> $stable(mosi_o));

    // R8: a rejected or non-shifting command never selects the device
    a_r8_skip_no_select: assert property (@(posedge clk) disable iff (rst)
        (st_q == EN_SKIP) |-> cs_n_q);

    // R3: bit position stays inside the programmed length
    a_r3_bit_in_range: assert property (@(posedge clk) disable iff (rst)
        shifting |-> (idx_q < nbits_q));

    // R5: trailing period keeps the device selected with the clock low
    a_r5_tail_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == EN_TAIL) |-> (!sck_q && !cs_n_q));

endmodule

// File: rtl/spi_prg_shifter.sv
module spi_prg_shifter import spi_prg_pkg::*; #(
    parameter  int PRG_BYTES = PRG_BYTES_DEF,
    parameter  int SHB_BYTES = SHB_BYTES_DEF,
    parameter  int HALF_DIV  = 2,
    localparam int MAX_BITS  = 8 * SHB_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic                busy;
    logic                done;
    logic                go;
    logic                frame;
    logic [DATA_W-1:0]   count;
    logic [DATA_W-1:0]   cmd;
    logic [MAX_BITS-1:0] out_vec;
    logic [MAX_BITS-1:0] rx_vec;

    prg_regfile #(
        .PRG_BYTES (PRG_BYTES),
        .SHB_BYTES (SHB_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy_i    (busy),
        .done_i    (done),
        .rx_vec_i  (rx_vec),
        .go_o      (go),
        .frame_o   (frame),
        .count_o   (count),
        .out_vec_o (out_vec),
        .cmd_o     (cmd)
    );

    prg_engine #(
        .MAX_BITS (MAX_BITS),
        .HALF_DIV (HALF_DIV)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .go_i     (go),
        .frame_i  (frame),
        .count_i  (count),
        .tx_vec_i (out_vec),
        .miso_i   (spi_miso),
        .sck_o    (spi_sck),
        .cs_n_o   (spi_cs_n),
        .mosi_o   (spi_mosi),
        .busy_o   (busy),
        .done_o   (done),
        .rx_vec_o (rx_vec)
    );

    // R7: a selected device always has the programmed trigger showing
    a_r7_trigger_covers_frame: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> cmd[TRG_PRG]);

    // R7: deselect and trigger release happen on one edge
    a_r7_clear_with_deselect: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> !cmd[TRG_PRG]);

endmodule

// File: tb/spi_prg_shifter_tb.sv
module spi_prg_shifter_tb;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int fails  = 0;

    // serial slave model
    logic [63:0] sl_tx = '0;
    logic [63:0] sl_rx = '0;
    int          sl_idx = 0;
    int          rises = 0;
    int          cs_low_cyc = 0;
    int          sck_idle_err = 0;

    always #5 clk = ~clk;

    spi_prg_shifter #(.HALF_DIV(H)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    assign spi_miso = (sl_idx < 64) ? sl_tx[63 - sl_idx] : 1'b0;

    always @(negedge spi_cs_n) sl_idx = 0;
    always @(negedge spi_sck) if (spi_cs_n === 1'b0) sl_idx = sl_idx + 1;
    always @(posedge spi_sck) begin
        sl_rx = {sl_rx[62:0], spi_mosi};
        rises = rises + 1;
    end
    always @(negedge clk) begin
        if (!rst && spi_cs_n === 1'b0) cs_low_cyc = cs_low_cyc + 1;
        if (!rst && spi_cs_n === 1'b1 && spi_sck !== 1'b0) sck_idle_err = sck_idle_err + 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_bank(output logic [63:0] v);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            rd(5'h10 + 5'(i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic clear_mon();
        sl_rx = '0; rises = 0; cs_low_cyc = 0;
    endtask

    // R7: poll until the trigger drops; it must drop with the deselect
    task automatic wait_done(input string req);
        logic [7:0] c;
        logic prev_low;
        int   n;
        prev_low = 1'b0;
        n = 0;
        rd(5'h00, c);
        while (c[2] && n < 5000) begin
            prev_low = (spi_cs_n === 1'b0);
            @(negedge clk);
            rd(5'h00, c);
            n++;
        end
        chk({req, " R7 trigger released"}, 64'(c[2]), 64'd0);
        chk({req, " R7 release with deselect"}, {62'd0, prev_low, spi_cs_n}, 64'd3);
    endtask

    task automatic load_prog(input logic [47:0] p);
        for (int i = 0; i < 6; i++) wr(5'h08 + 5'(i), p[8*i +: 8]);
    endtask

    // R3 R4 R5 R6: a full programmed frame
    task automatic t_frame(input string req, input int n, input logic [47:0] p, input logic [63:0] pat);
        logic [63:0] ev, bank;
        load_prog(p);
        wr(5'h01, 8'(n));
        sl_tx = pat;
        clear_mon();
        wr(5'h00, 8'h04);
        wait_done(req);
        ev = {p, 16'h0};
        chk({req, " R3 mosi bits"}, sl_rx, ev >> (64 - n));
        chk({req, " R4 rising edges"}, 64'(rises), 64'(n));
        chk({req, " R5 select length"}, 64'(cs_low_cyc), 64'(2*H*(n+1)));
        rd_bank(bank);
        chk({req, " R6 shift bank"}, bank, pat >> (64 - n));
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), d);
            chk("R1 reset reg", {24'(a), 32'd0, d}, {24'(a), 40'd0});
        end
        chk("R1 reset pins", {61'd0, spi_cs_n, spi_sck, spi_mosi}, 64'd4);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(5'h01, 8'h5A); rd(5'h01, d); chk("R2 count readback", 64'(d), 64'h5A);
        load_prog(48'hA5_96_3C_0F_F0_11);
        rd(5'h0D, d); chk("R2 prog5 readback", 64'(d), 64'hA5);
        rd(5'h08, d); chk("R2 prog0 readback", 64'(d), 64'h11);
        rd(5'h05, d); chk("R2 unmapped 05", 64'(d), 64'h0);
        rd(5'h0E, d); chk("R2 unmapped 0E", 64'(d), 64'h0);
        rd(5'h18, d); chk("R2 unmapped 18", 64'(d), 64'h0);
        wr(5'h00, 8'h48); rd(5'h00, d); chk("R2 bits 3 and 6 not stored", 64'(d), 64'h0);
    endtask

    task automatic t_r6_order();
        logic [7:0] d;
        t_frame("R6 three bytes", 24, 48'h9F_00_00_00_00_00, 64'h11_C2_20_18_00_00_00_00);
        rd(5'h10, d); chk("R6 index0 is last byte", 64'(d), 64'h20);
        rd(5'h12, d); chk("R6 index2 is first byte", 64'(d), 64'h11);
        rd(5'h13, d); chk("R6 unused byte zero", 64'(d), 64'h0);
    endtask

    task automatic t_bad_count(input string req, input logic [7:0] cnt);
        logic [7:0] d;
        logic [63:0] b0, b1;
        rd_bank(b0);
        wr(5'h01, cnt);
        clear_mon();
        wr(5'h00, 8'h04);
        rd(5'h00, d); chk({req, " R8 trigger set one cycle"}, 64'(d), 64'h04);
        @(negedge clk);
        rd(5'h00, d); chk({req, " R8 trigger cleared"}, 64'(d), 64'h00);
        repeat (10) @(negedge clk);
        chk({req, " R8 no select"}, 64'(cs_low_cyc), 64'd0);
        rd_bank(b1);
        chk({req, " R8 bank kept"}, b1, b0);
    endtask

    task automatic t_other_trig(input logic [7:0] v);
        logic [7:0] d;
        clear_mon();
        wr(5'h00, v);
        rd(5'h00, d); chk("R9 other trigger seen", 64'(d), 64'(v));
        @(negedge clk);
        rd(5'h00, d); chk("R9 other trigger cleared", 64'(d), 64'h0);
        repeat (6) @(negedge clk);
        chk("R9 no bus activity", {32'(cs_low_cyc), 32'(rises)}, 64'd0);
    endtask

    task automatic t_ainc();
        logic [7:0] d;
        wr(5'h01, 8'd16);
        clear_mon();
        wr(5'h00, 8'h84);
        wait_done("R10");
        rd(5'h00, d); chk("R10 auto-increment kept", 64'(d), 64'h80);
        wr(5'h00, 8'h00);
        rd(5'h00, d); chk("R10 auto-increment cleared by write", 64'(d), 64'h00);
    endtask

    task automatic t_busy_cmd();
        logic [7:0] d;
        load_prog(48'h3B_12_34_56_00_00);
        wr(5'h01, 8'd16);
        sl_tx = 64'hC3A5_0000_0000_0000;
        clear_mon();
        wr(5'h00, 8'h04);
        wr(5'h00, 8'h01);
        rd(5'h00, d); chk("R11 cmd unchanged while busy", 64'(d), 64'h04);
        wait_done("R11");
        repeat (20) @(negedge clk);
        chk("R11 single frame", {32'(cs_low_cyc), 32'(rises)}, {32'(2*H*17), 32'd16});
        chk("R11 frame bits", sl_rx, 64'h3B12);
    endtask

    task automatic t_busy_regs();
        logic [7:0] d;
        load_prog(48'h0B_AB_CD_EF_77_00);
        wr(5'h01, 8'd32);
        sl_tx = 64'h0;
        clear_mon();
        wr(5'h00, 8'h04);
        wr(5'h0D, 8'hEE);
        wr(5'h01, 8'd8);
        wait_done("R12");
        chk("R12 frame used old bytes", sl_rx, 64'h0BABCDEF);
        chk("R12 frame used old count", 64'(rises), 64'd32);
        rd(5'h0D, d); chk("R12 prog5 updated", 64'(d), 64'hEE);
        rd(5'h01, d); chk("R12 count updated", 64'(d), 64'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_frame("R3 opcode only", 8, 48'h06_00_00_00_00_00, 64'hFF00_0000_0000_0000);
        t_frame("R3 opcode+addr", 32, 48'h03_12_34_56_00_00, 64'h0000_0000_0000_0000);
        t_frame("R3 full length", 64, 48'hA1_B2_C3_D4_E5_F6, 64'h0123_4567_89AB_CDEF);
        t_frame("R3 odd length", 12, 48'h5C_F0_00_00_00_00, 64'hABC0_0000_0000_0000);
        t_frame("R3 single bit", 1, 48'h80_00_00_00_00_00, 64'h8000_0000_0000_0000);
        t_r6_order();
        t_bad_count("zero", 8'd0);
        t_bad_count("oversize", 8'd65);
        t_other_trig(8'h01);
        t_other_trig(8'h02);
        t_other_trig(8'h10);
        t_other_trig(8'h20);
        t_ainc();
        t_busy_cmd();
        t_busy_regs();
        chk("R4 clock idle low when deselected", 64'(sck_idle_err), 64'd0);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule